// File: doc/BRIEF.md
# Console ROM Bank Mapper

This block lets an 8-bit Z80 console address a cartridge ROM much larger than its 64 KB address space. It watches the CPU memory bus and drives the upper ROM address lines and the ROM chip enable. The lower 48 KB of CPU space is split into three 16 KB windows. The window at 0x0000 always shows ROM page 0. The windows at 0x4000 and 0x8000 each show a page chosen by a bank register. Software sets those registers by writing to the top two bytes of the CPU address space.

A strap input selects pass-through mode. In that mode the block acts as a plain 32 KB cartridge and ignores the bank registers.

Parameters set the number of implemented page bits, which trades ROM size for register width. A second parameter removes the window-1 register, so that window 1 maps linearly to page 1. The block is clocked by a bus-rate clock, and the CPU bus strobes are sampled on that clock.

Top module: `rom_bank_mapper`

## Requirements
- R1: After reset, window 1 (CPU 0x4000–0x7FFF) shows page 1 and window 2 (CPU 0x8000–0xBFFF) shows page 2.
- R2: With CPU A15:A14 = 00, rom_addr_o[21:14] is 0. In every mode, rom_addr_o[13:0] equals CPU A13:A0.
- R3: A write with mreq_n_i and wr_n_i low at CPU address 0xFFFE loads cpu_data_i into the window-1 register. The new page is visible on the first clock edge that samples wr_n_i high again.
- R4: A write to 0xFFFF loads the window-2 register with the same timing as R3.
- R5: Outside pass-through mode, rom_addr_o[21:14] is the window-1 page when A15:A14 = 01 and the window-2 page when A15:A14 = 10.
- R6: rom_ce_no is low only while mreq_n_i and rd_n_i are both low and the CPU address is below 0xC000. A write never drives it low.
- R7: With pass_i high, rom_addr_o[21:15] is 0 and rom_addr_o[14] equals CPU A14. rom_ce_no is low only for reads below 0x8000.
- R8: With PAGE_BITS below 8, a bank write keeps only the low PAGE_BITS data bits, and rom_addr_o bits above 13+PAGE_BITS stay 0.
- R9: Bus cycles other than a memory write to 0xFFFE or 0xFFFF leave both bank registers unchanged. This includes a write strobe with mreq_n_i high.
- R10: With W1_BANKED = 0, window 1 always shows page 1, and writes to 0xFFFE have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus sampling clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cpu_addr_i | input | 16 | CPU address bus |
| cpu_data_i | input | 8 | CPU data bus |
| mreq_n_i | input | 1 | Memory request, active low |
| rd_n_i | input | 1 | Read strobe, active low |
| wr_n_i | input | 1 | Write strobe, active low |
| pass_i | input | 1 | Strap for flat 32 KB pass-through |
| rom_addr_o | output | 22 | ROM address (page bits above bit 13) |
| rom_ce_no | output | 1 | ROM chip enable, active low |

## Verification
Two events can land on the same clock edge: a bank register update and a read through the window that register controls. The bench provokes this by raising the write strobe at the same moment it starts a read of window 2. It then checks that the address sampled after that edge already carries the new page, and that the chip enable is asserted for the read. Randomly ordered writes, stray writes and reads, with and without the strap, are compared against a bench-side page model. A second instance built with 5 page bits and no window-1 register is compared in parallel against the same stimulus.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  localparam int unsigned WIN_BITS   = 14;
  localparam int unsigned MAX_PAGE_W = 8;
  localparam int unsigned CPU_AW     = 16;
  localparam int unsigned ROM_AW     = WIN_BITS + MAX_PAGE_W;

  typedef enum logic [1:0] {
    WIN_FIXED = 2'd0,
    WIN_ONE   = 2'd1,
    WIN_TWO   = 2'd2,
    WIN_HIGH  = 2'd3
  } win_e;

  // Bank register addresses share all bits but bit 0; bit 0 picks the window.
  localparam logic [CPU_AW-2:0] REG_ADDR_HI = 15'h7FFF;
endpackage

// File: rtl/rbm_bank_regs.sv
module rbm_bank_regs
  import rbm_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 8,
  parameter bit          W1_BANKED = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CPU_AW-1:0]    addr_i,
  input  logic [7:0]           data_i,
  input  logic                 mreq_n_i,
  input  logic                 wr_n_i,
  output logic [PAGE_BITS-1:0] w1_page_o,
  output logic [PAGE_BITS-1:0] w2_page_o
);
  localparam logic [PAGE_BITS-1:0] W1_RESET = PAGE_BITS'(1);
  localparam logic [PAGE_BITS-1:0] W2_RESET = PAGE_BITS'(2);

  logic                 armed_q;
  logic                 sel_w2_q;
  logic [PAGE_BITS-1:0] stage_q;
  logic                 hit;
  logic                 commit;
  logic [PAGE_BITS-1:0] w2_q;

  assign hit    = !mreq_n_i && !wr_n_i && (addr_i[CPU_AW-1:1] == REG_ADDR_HI);
  assign commit = armed_q && wr_n_i;

  // Staging follows the bus while the strobe is low; commit on strobe release.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q  <= 1'b0;
      sel_w2_q <= 1'b0;
      stage_q  <= '0;
    end else if (hit) begin
      armed_q  <= 1'b1;
      sel_w2_q <= addr_i[0];
      stage_q  <= data_i[PAGE_BITS-1:0];
    end else if (commit) begin
      armed_q  <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 w2_q <= W2_RESET;
    else if (commit && sel_w2_q) w2_q <= stage_q;
  end
  assign w2_page_o = w2_q;

  generate
    if (W1_BANKED) begin : g_w1_reg
      logic [PAGE_BITS-1:0] w1_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                  w1_q <= W1_RESET;
        else if (commit && !sel_w2_q) w1_q <= stage_q;
      end
      assign w1_page_o = w1_q;

      p_w1_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (commit && !sel_w2_q) |=> (w1_page_o == $past(stage_q)));
      p_w1_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(commit && !sel_w2_q) |=> $stable(w1_page_o));
    end else begin : g_w1_fixed
      assign w1_page_o = W1_RESET;
    end
  endgenerate

  p_w2_load_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (commit && sel_w2_q) |=> (w2_page_o == $past(stage_q)));
  p_w2_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(commit && sel_w2_q) |=> $stable(w2_page_o));
endmodule

// File: rtl/rbm_addr_map.sv
module rbm_addr_map
  import rbm_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [CPU_AW-1:0]    addr_i,
  input  logic                 mreq_n_i,
  input  logic                 rd_n_i,
  input  logic                 pass_i,
  input  logic [PAGE_BITS-1:0] w1_page_i,
  input  logic [PAGE_BITS-1:0] w2_page_i,
  output logic [ROM_AW-1:0]    rom_addr_o,
  output logic                 rom_ce_no
);
  win_e                  win;
  logic [PAGE_BITS-1:0]  page_sel;
  logic [MAX_PAGE_W-1:0] upper;
  logic                  in_range;

  assign win = win_e'(addr_i[CPU_AW-1:WIN_BITS]);

  always_comb begin
    unique case (win)
      WIN_FIXED: page_sel = '0;
      WIN_ONE:   page_sel = w1_page_i;
      default:   page_sel = w2_page_i;
    endcase
  end

  always_comb begin
    if (pass_i) upper = MAX_PAGE_W'(addr_i[WIN_BITS]);
    else        upper = MAX_PAGE_W'(page_sel);
  end

  assign in_range   = pass_i ? !addr_i[CPU_AW-1] : (win != WIN_HIGH);
  assign rom_addr_o = {upper, addr_i[WIN_BITS-1:0]};
  assign rom_ce_no  = !(!mreq_n_i && !rd_n_i && in_range);

  p_ce_read_only_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rom_ce_no |-> (!mreq_n_i && !rd_n_i && (addr_i < 16'hC000)));
  p_win0_page0_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i[15:14] == 2'b00) |-> (rom_addr_o[ROM_AW-1:WIN_BITS] == '0));
  p_pass_flat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pass_i |-> (rom_addr_o[ROM_AW-1:WIN_BITS+1] == '0 && rom_addr_o[WIN_BITS] == addr_i[WIN_BITS]));

  generate
    if (PAGE_BITS < MAX_PAGE_W) begin : g_trunc_chk
      p_upper_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rom_addr_o[ROM_AW-1:WIN_BITS+PAGE_BITS] == '0);
    end
  endgenerate
endmodule

// File: rtl/rom_bank_mapper.sv
module rom_bank_mapper
  import rbm_pkg::*;
#(
  parameter int unsigned PAGE_BITS = 8,
  parameter bit          W1_BANKED = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [15:0] cpu_addr_i,
  input  logic [7:0]  cpu_data_i,
  input  logic        mreq_n_i,
  input  logic        rd_n_i,
  input  logic        wr_n_i,
  input  logic        pass_i,
  output logic [21:0] rom_addr_o,
  output logic        rom_ce_no
);
  logic [PAGE_BITS-1:0] w1_page;
  logic [PAGE_BITS-1:0] w2_page;

  rbm_bank_regs #(.PAGE_BITS(PAGE_BITS), .W1_BANKED(W1_BANKED)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .addr_i    (cpu_addr_i),
    .data_i    (cpu_data_i),
    .mreq_n_i  (mreq_n_i),
    .wr_n_i    (wr_n_i),
    .w1_page_o (w1_page),
    .w2_page_o (w2_page)
  );

  rbm_addr_map #(.PAGE_BITS(PAGE_BITS)) u_map (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (cpu_addr_i),
    .mreq_n_i   (mreq_n_i),
    .rd_n_i     (rd_n_i),
    .pass_i     (pass_i),
    .w1_page_i  (w1_page),
    .w2_page_i  (w2_page),
    .rom_addr_o (rom_addr_o),
    .rom_ce_no  (rom_ce_no)
  );
endmodule

// File: tb/rom_bank_mapper_test.sv
module rom_bank_mapper_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic [7:0]  data = 8'h00;
  logic        mreq_n = 1'b1;
  logic        rd_n = 1'b1;
  logic        wr_n = 1'b1;
  logic        pass = 1'b0;
  logic [21:0] rom_a, rom_b;
  logic        ce_a, ce_b;

  int checks = 0;
  int fails = 0;
  logic [7:0] m_w1 = 8'd1, m_w2 = 8'd2, n_w2 = 8'd2;

  always #10 clk = ~clk;

  rom_bank_mapper uut (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_data_i(data),
    .mreq_n_i(mreq_n), .rd_n_i(rd_n), .wr_n_i(wr_n), .pass_i(pass),
    .rom_addr_o(rom_a), .rom_ce_no(ce_a));

  // Reduced build: 5 page bits, window 1 linear
  rom_bank_mapper #(.PAGE_BITS(5), .W1_BANKED(1'b0)) uut_lin (
    .clk_i(clk), .rst_ni(rst_n), .cpu_addr_i(addr), .cpu_data_i(data),
    .mreq_n_i(mreq_n), .rd_n_i(rd_n), .wr_n_i(wr_n), .pass_i(pass),
    .rom_addr_o(rom_b), .rom_ce_no(ce_b));

  function automatic logic [21:0] exp_rom(input logic [15:0] a, input logic p,
                                          input logic [7:0] p1, input logic [7:0] p2,
                                          input int pb);
    logic [7:0] pg;
    logic [7:0] mask;
    mask = 8'hFF >> (8 - pb);
    if (p) pg = {7'd0, a[14]};
    else begin
      case (a[15:14])
        2'b00:   pg = 8'd0;
        2'b01:   pg = p1;
        default: pg = p2;
      endcase
    end
    pg = pg & mask;
    return {pg, a[13:0]};
  endfunction

  function automatic logic exp_ce(input logic [15:0] a, input logic p, input logic rd);
    logic hit;
    hit = p ? (a < 16'h8000) : (a < 16'hC000);
    return !(rd && hit);
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_read(input logic [15:0] a, input string tag);
    @(negedge clk);
    addr = a; mreq_n = 1'b0; rd_n = 1'b0; wr_n = 1'b1;
    @(posedge clk); #5;
    check({tag, " ce"}, {31'd0, ce_a}, {31'd0, exp_ce(a, pass, 1'b1)});
    check({tag, " ce lin"}, {31'd0, ce_b}, {31'd0, exp_ce(a, pass, 1'b1)});
    if (pass || a < 16'hC000) begin
      check({tag, " addr"}, {10'd0, rom_a}, {10'd0, exp_rom(a, pass, m_w1, m_w2, 8)});
      check({tag, " addr lin"}, {10'd0, rom_b}, {10'd0, exp_rom(a, pass, 8'd1, n_w2, 5)});
    end
    @(negedge clk);
    mreq_n = 1'b1; rd_n = 1'b1;
  endtask

  // mreq selects a real memory write or a stray strobe (R9)
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic mreq);
    @(negedge clk);
    addr = a; data = d; mreq_n = !mreq; wr_n = 1'b0; rd_n = 1'b1;
    @(posedge clk); #5;
    check("R6 ce off during write", {31'd0, ce_a}, 32'd1);
    @(negedge clk);
    wr_n = 1'b1; mreq_n = 1'b1;
    if (mreq && a == 16'hFFFE) m_w1 = d;
    if (mreq && a == 16'hFFFF) begin m_w2 = d; n_w2 = d & 8'h1F; end
    @(posedge clk); #5;
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog all requirements actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] ra;
    logic [7:0]  rd8;
    int          sel;
    void'($urandom(32'd7431));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #5;
    check("R6 idle ce", {31'd0, ce_a}, 32'd1);
    check_read(16'h4123, "R1 reset window1");
    check_read(16'h8456, "R1 reset window2");
    check_read(16'h0ABC, "R2 window0");
    check_read(16'hC000, "R6 above C000");

    bus_write(16'hFFFE, 8'h3C, 1'b1);
    check_read(16'h7FFF, "R3 window1 load");
    bus_write(16'hFFFF, 8'hE7, 1'b1);
    check_read(16'h8001, "R4 R8 window2 load trunc");
    check_read(16'h4000, "R10 linear window1");
    check_read(16'h3FFF, "R2 window0 after banking");

    bus_write(16'hFFFF, 8'h11, 1'b0);
    check_read(16'h8000, "R9 stray no mreq");
    bus_write(16'hFFFD, 8'h22, 1'b1);
    check_read(16'hBFFF, "R9 other address");

    pass = 1'b1;
    check_read(16'h4ABC, "R7 pass upper");
    check_read(16'h8000, "R7 pass ce off");
    pass = 1'b0;

    // Commit and a read of the same window meet on one edge
    @(negedge clk);
    addr = 16'hFFFF; data = 8'h5A; mreq_n = 1'b0; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1; rd_n = 1'b0; addr = 16'h8123;
    m_w2 = 8'h5A; n_w2 = 8'h1A;
    @(posedge clk); #5;
    check("R4 R5 same edge addr", {10'd0, rom_a}, {10'd0, exp_rom(16'h8123, 1'b0, m_w1, m_w2, 8)});
    check("R8 same edge addr lin", {10'd0, rom_b}, {10'd0, exp_rom(16'h8123, 1'b0, 8'd1, n_w2, 5)});
    check("R6 same edge ce", {31'd0, ce_a}, 32'd0);
    @(negedge clk); mreq_n = 1'b1; rd_n = 1'b1;

    for (int i = 0; i < 400; i++) begin
      sel = $urandom_range(0, 9);
      ra  = 16'($urandom);
      rd8 = 8'($urandom);
      pass = ($urandom_range(0, 7) == 0);
      case (sel)
        0, 1: bus_write(16'hFFFE, rd8, 1'b1);
        2, 3: bus_write(16'hFFFF, rd8, 1'b1);
        4:    bus_write(ra, rd8, 1'b1);
        5:    bus_write({15'h7FFF, ra[0]}, rd8, 1'b0);
        default: check_read(ra, "R5 R7 random read");
      endcase
    end
    pass = 1'b0;
    check_read(16'h4000, "R3 final window1");
    check_read(16'h8000, "R4 final window2");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule